// File: doc/BRIEF.md
# Indirect Gather Request Streamer

This block reads a list of column indices out of one memory and uses each of them as the address for a read of a second memory, which holds a vector. It returns the fetched vector words as a valid/ready stream. The i-th output word is vec[col[i]], and outputs leave in element order. Downstream logic can therefore pair every output with the matrix value at the same position. Because each vector address comes from read data rather than from a counter, the vector memory sees a random, data-dependent access pattern. The two reads are chained, with one cycle between them.

A run begins with a one-cycle start pulse that carries the element count. The block reads the index memory at addresses 0, 1, 2 and so on up to count−1. Each index that comes back goes out unchanged as the vector-memory address on the next cycle. The vector word that returns one cycle after that is placed in a small FIFO, which drives the output stream. Both memories are synchronous-read RAMs with exactly one cycle of latency. The block stops issuing index reads while the reads in flight plus the words already buffered would fill the FIFO. This means output backpressure can never cause a word to be lost. A one-cycle done pulse closes the run once the last output word has been taken.

Top module: `gather_streamer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, done_o, out_valid_o, col_rd_en_o and vec_rd_en_o are all 0.
- R2: After a start pulse with count N > 0, col_rd_en_o is asserted exactly N times. The addresses on col_rd_addr_o take the values 0, 1, …, N−1 in that order, and none is skipped or repeated.
- R3: One cycle after every index read, vec_rd_en_o is 1 and vec_rd_addr_o equals the word the index memory returned for that read, unchanged. vec_rd_en_o is never 1 in any other cycle.
- R4: The k-th word accepted on the output (out_valid_o and out_ready_i both 1) equals vec[col[k]] for k = 0…N−1. This holds when indices repeat and when an index takes its largest value.
- R5: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged on the next cycle. No word is dropped or duplicated under any ready pattern.
- R6: At every clock edge, the number of index reads issued minus the number of output words accepted is at most FIFO_DEPTH. If out_ready_i stays low, exactly FIFO_DEPTH index reads are issued and then issuing stops.
- R7: done_o is a single-cycle pulse. It is asserted in the cycle right after the clock edge at which the final output word is accepted. busy_o is 1 from the cycle after an accepted start until that done pulse.
- R8: A start with count 0 produces a done pulse in the cycle after the start and issues no memory reads.
- R9: A start pulse while busy_o is 1 is ignored. The current run keeps its original count and emits exactly that many words and one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse that starts a run |
| count_i | input | CNT_W | Number of elements in the run, sampled with start_i |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse after the last output word is accepted |
| col_rd_en_o | output | 1 | Read enable to the column-index memory |
| col_rd_addr_o | output | CNT_W | Element position being read |
| col_rd_data_i | input | IDX_W | Index word, valid one cycle after the read |
| vec_rd_en_o | output | 1 | Read enable to the vector memory |
| vec_rd_addr_o | output | IDX_W | Vector address, equal to the returned index |
| vec_rd_data_i | input | DATA_W | Vector word, valid one cycle after the read |
| out_valid_o | output | 1 | Output word available |
| out_data_o | output | DATA_W | Output word vec[col[i]] |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The bench first holds out_ready_i low for a long stretch. A design that counted only buffered words, and not reads still in flight, would issue more than FIFO_DEPTH reads and overwrite a FIFO entry. The bench also sees this as a corrupted or missing word once ready rises. An index table with repeated entries and the maximum index value catches a design that increments the vector address instead of forwarding the returned data. A ready signal that toggles exposes words that get duplicated or change while stalled. Three further runs use count 0, count 1 and a second start issued mid-run. A design that got these wrong would hang without a done pulse, emit a spurious read, or restart and emit the wrong number of words.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gs_state_e;
endpackage

// File: rtl/gs_req_ctrl.sv
module gs_req_ctrl
  import gs_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             credit_ok_i,
  input  logic             out_fire_i,
  output logic             col_rd_en_o,
  output logic [CNT_W-1:0] col_rd_addr_o,
  output logic             busy_o,
  output logic             done_o
);
  gs_state_e        state_q, state_d;
  logic [CNT_W-1:0] issue_q, issue_d;
  logic [CNT_W-1:0] total_q, total_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             done_q, done_d;
  logic             issue_en;
  logic             load_en;

  assign issue_en = (state_q == ST_RUN) && (issue_q != total_q) && credit_ok_i;
  assign load_en  = (state_q == ST_IDLE) && start_i && (count_i != '0);

  always_comb begin
    state_d = state_q;
    issue_d = issue_q;
    total_d = total_q;
    left_d  = left_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (count_i == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            issue_d = '0;
            total_d = count_i;
            left_d  = count_i;
          end
        end
      end
      default: begin
        if (issue_en) issue_d = issue_q + 1'b1;
        if (out_fire_i) begin
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      issue_q <= '0;
      total_q <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_en || issue_en) issue_q <= issue_d;
      if (load_en) total_q <= total_d;
      if (load_en || out_fire_i) left_q <= left_d;
    end
  end

  assign col_rd_en_o   = issue_en;
  assign col_rd_addr_o = issue_q;
  assign busy_o        = (state_q == ST_RUN);
  assign done_o        = done_q;

  // R2: consecutive reads step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd_en_o |=> (!col_rd_en_o || col_rd_addr_o == $past(col_rd_addr_o) + 1'b1));
  // R2: never read beyond the run length
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd_en_o |-> (col_rd_addr_o < total_q));
  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9: start during a run leaves the run length alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (total_q == $past(total_q)));
endmodule

// File: rtl/gs_pipe.sv
module gs_pipe #(
  parameter int FIFO_DEPTH = 4,
  parameter int FCNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              col_rd_en_i,
  input  logic [FCNT_W-1:0] fifo_cnt_i,
  output logic              col_vld_o,
  output logic              vec_vld_o,
  output logic              credit_ok_o
);
  localparam int SUM_W = FCNT_W + 1;

  logic             col_vld_q, col_vld_d;
  logic             vec_vld_q, vec_vld_d;
  logic [SUM_W-1:0] occupancy;

  always_comb begin
    col_vld_d = col_rd_en_i;
    vec_vld_d = col_vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_vld_q <= 1'b0;
      vec_vld_q <= 1'b0;
    end else begin
      col_vld_q <= col_vld_d;
      vec_vld_q <= vec_vld_d;
    end
  end

  assign occupancy   = SUM_W'(fifo_cnt_i) + SUM_W'(col_vld_q) + SUM_W'(vec_vld_q);
  assign credit_ok_o = (occupancy < SUM_W'(FIFO_DEPTH));
  assign col_vld_o   = col_vld_q;
  assign vec_vld_o   = vec_vld_q;

  // R6: reads in flight plus stored words never exceed the FIFO
  a_r6_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= SUM_W'(FIFO_DEPTH));
endmodule

// File: rtl/gs_fifo.sv
module gs_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16,
  parameter int FCNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [FCNT_W-1:0] cnt_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [FCNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    rd_d  = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d = cnt_q;
    if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
    if (!push_i && pop_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_d;
      if (pop_i)  rd_q <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_i && (wr_q == AW'(g))) mem[g] <= push_data_i;
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
  assign cnt_o   = cnt_q;

  // R6: no write into a full FIFO
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < FCNT_W'(DEPTH)) || pop_i);
  // R5: a stalled head stays put
  a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
  // R5: nothing is popped from an empty FIFO
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> valid_o);
endmodule

// File: rtl/gather_streamer.sv
module gather_streamer #(
  parameter int CNT_W      = 10,
  parameter int IDX_W      = 8,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              col_rd_en_o,
  output logic [CNT_W-1:0]  col_rd_addr_o,
  input  logic [IDX_W-1:0]  col_rd_data_i,
  output logic              vec_rd_en_o,
  output logic [IDX_W-1:0]  vec_rd_addr_o,
  input  logic [DATA_W-1:0] vec_rd_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic              credit_ok;
  logic              col_vld;
  logic              vec_vld;
  logic              out_fire;
  logic [FCNT_W-1:0] fifo_cnt;

  assign out_fire = out_valid_o && out_ready_i;

  gs_req_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .count_i       (count_i),
    .credit_ok_i   (credit_ok),
    .out_fire_i    (out_fire),
    .col_rd_en_o   (col_rd_en_o),
    .col_rd_addr_o (col_rd_addr_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  gs_pipe #(.FIFO_DEPTH(FIFO_DEPTH), .FCNT_W(FCNT_W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .col_rd_en_i (col_rd_en_o),
    .fifo_cnt_i  (fifo_cnt),
    .col_vld_o   (col_vld),
    .vec_vld_o   (vec_vld),
    .credit_ok_o (credit_ok)
  );

  assign vec_rd_en_o   = col_vld;
  assign vec_rd_addr_o = col_rd_data_i;

  gs_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W), .FCNT_W(FCNT_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (vec_vld),
    .push_data_i (vec_rd_data_i),
    .pop_i       (out_fire),
    .valid_o     (out_valid_o),
    .data_o      (out_data_o),
    .cnt_o       (fifo_cnt)
  );

  // R3: every index read is followed by a vector read
  a_r3_vec_follows: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd_en_o |=> vec_rd_en_o);
  // R7: the FIFO is empty when done fires
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o);
  // R8: empty run finishes at once
  a_r8_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && count_i == '0) |=> (done_o && !busy_o));
endmodule

// File: tb/test_gather_streamer.sv
`timescale 1ns/1ps
module test_gather_streamer;
  localparam int CNT_W = 10, IDX_W = 8, DATA_W = 16, DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic out_ready_i = 1'b0;
  logic busy_o, done_o, col_rd_en_o, vec_rd_en_o, out_valid_o;
  logic [CNT_W-1:0] col_rd_addr_o;
  logic [IDX_W-1:0] col_rd_data_i, vec_rd_addr_o;
  logic [DATA_W-1:0] vec_rd_data_i, out_data_o;

  always #10 clk = ~clk;

  gather_streamer #(.CNT_W(CNT_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .FIFO_DEPTH(DEPTH)) i_gather_streamer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .busy_o(busy_o), .done_o(done_o),
    .col_rd_en_o(col_rd_en_o), .col_rd_addr_o(col_rd_addr_o), .col_rd_data_i(col_rd_data_i),
    .vec_rd_en_o(vec_rd_en_o), .vec_rd_addr_o(vec_rd_addr_o), .vec_rd_data_i(vec_rd_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  logic [IDX_W-1:0]  col_mem [256];
  logic [DATA_W-1:0] vec_mem [256];

  always @(posedge clk) begin
    if (col_rd_en_o) col_rd_data_i <= col_mem[col_rd_addr_o[7:0]];
    if (vec_rd_en_o) vec_rd_data_i <= vec_mem[vec_rd_addr_o];
  end

  int errors = 0, checks = 0, cyc = 0;
  int rdy_mode = 0, release_cyc = 0;
  bit finished = 0;

  // monitor state
  int mon_issued, mon_acc, mon_done, mon_next_addr, done_cyc, last_acc, start_win;
  int addr_err, vec_err, data_err, hold_err, bound_err;
  bit prev_col_en, prev_stall;
  int prev_col_addr;
  logic [DATA_W-1:0] prev_data;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    mon_issued = 0; mon_acc = 0; mon_done = 0; mon_next_addr = 0;
    done_cyc = -1; last_acc = -1; start_win = -1;
    addr_err = 0; vec_err = 0; data_err = 0; hold_err = 0; bound_err = 0;
    prev_col_en = 0; prev_stall = 0; prev_col_addr = 0; prev_data = '0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready_i <= 1'b1;
      1: out_ready_i <= (cyc % 3) != 0;
      default: out_ready_i <= (cyc >= release_cyc);
    endcase
  end

  // sampling 2 ns before each rising edge
  always begin
    @(posedge clk);
    #18;
    if (rst_n) begin
      if (start_i && start_win < 0) start_win = cyc;
      if (vec_rd_en_o) begin
        if (!prev_col_en || vec_rd_addr_o != col_mem[prev_col_addr[7:0]]) vec_err++;
      end else if (prev_col_en) vec_err++;
      prev_col_en = col_rd_en_o;
      prev_col_addr = int'(col_rd_addr_o);
      if (col_rd_en_o) begin
        if (int'(col_rd_addr_o) != mon_next_addr) addr_err++;
        mon_next_addr++;
        mon_issued++;
      end
      if (prev_stall && (!out_valid_o || out_data_o != prev_data)) hold_err++;
      prev_stall = out_valid_o && !out_ready_i;
      prev_data = out_data_o;
      if (out_valid_o && out_ready_i) begin
        if (out_data_o != vec_mem[col_mem[mon_acc[7:0]]]) data_err++;
        mon_acc++;
        last_acc = cyc;
      end
      if (mon_issued - mon_acc > DEPTH) bound_err++;
      if (done_o) begin
        mon_done++;
        done_cyc = cyc;
      end
    end
  end

  task automatic run(input int n, input int mode, input string tag);
    int guard;
    mon_clear();
    rdy_mode = mode;
    release_cyc = cyc + 40;
    @(negedge clk);
    start_i = 1'b1;
    count_i = CNT_W'(n);
    @(negedge clk);
    start_i = 1'b0;
    guard = 0;
    while (mon_done == 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk(mon_done == 1, {tag, " R7 one done pulse"}, mon_done, 1);
    chk(mon_acc == n, {tag, " R4 output count"}, mon_acc, n);
    chk(data_err == 0, {tag, " R4 output values"}, data_err, 0);
    chk(mon_issued == n && addr_err == 0, {tag, " R2 index reads"}, mon_issued, n);
    chk(vec_err == 0, {tag, " R3 vector address"}, vec_err, 0);
    chk(hold_err == 0, {tag, " R5 stall hold"}, hold_err, 0);
    chk(bound_err == 0, {tag, " R6 occupancy bound"}, bound_err, 0);
    if (n > 0) chk(done_cyc == last_acc + 1, {tag, " R7 done timing"}, done_cyc, last_acc + 1);
    chk(!busy_o, {tag, " R7 busy low after done"}, int'(busy_o), 0);
  endtask

  task automatic t_reset();
    #5;
    chk(!busy_o && !done_o && !out_valid_o && !col_rd_en_o && !vec_rd_en_o,
        "R1 outputs in reset", int'({busy_o, done_o, out_valid_o, col_rd_en_o, vec_rd_en_o}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !out_valid_o && !col_rd_en_o && !vec_rd_en_o,
        "R1 outputs after reset", int'({busy_o, done_o, out_valid_o, col_rd_en_o, vec_rd_en_o}), 0);
  endtask

  task automatic t_stall();
    mon_clear();
    rdy_mode = 2;
    release_cyc = cyc + 40;
    @(negedge clk);
    start_i = 1'b1;
    count_i = CNT_W'(12);
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < release_cyc - 3) @(negedge clk);
    #5;
    chk(mon_issued == DEPTH, "R6 reads stop at FIFO depth", mon_issued, DEPTH);
    chk(out_valid_o && out_data_o == vec_mem[col_mem[0]], "R5 head held while stalled",
        int'(out_data_o), int'(vec_mem[col_mem[0]]));
    while (mon_done == 0 && cyc < release_cyc + 2000) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(mon_acc == 12 && data_err == 0, "R5 stall run no loss", mon_acc, 12);
    chk(bound_err == 0 && hold_err == 0, "R6 stall run bound", bound_err + hold_err, 0);
  endtask

  task automatic t_zero();
    mon_clear();
    rdy_mode = 0;
    @(negedge clk);
    start_i = 1'b1;
    count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(mon_done == 1 && done_cyc == start_win + 1, "R8 zero count done timing", done_cyc, start_win + 1);
    chk(mon_issued == 0 && !busy_o, "R8 zero count no reads", mon_issued, 0);
  endtask

  task automatic t_restart();
    mon_clear();
    rdy_mode = 1;
    @(negedge clk);
    start_i = 1'b1;
    count_i = CNT_W'(10);
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    count_i = CNT_W'(5);
    @(negedge clk);
    start_i = 1'b0;
    while (mon_done == 0 && cyc < 150000) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(mon_acc == 10 && mon_issued == 10, "R9 start while busy ignored", mon_acc, 10);
    chk(mon_done == 1 && data_err == 0, "R9 single done, correct data", mon_done, 1);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      col_mem[a] = IDX_W'((a * 37 + 11) & 255);
      vec_mem[a] = DATA_W'(((a * 613 + 4097) ^ (a << 7)) & 16'hFFFF);
    end
    col_mem[3] = col_mem[2];
    col_mem[4] = col_mem[2];
    col_mem[5] = 8'd255;
    col_mem[9] = 8'd0;
    mon_clear();
    t_reset();
    run(40, 0, "free-running ready");
    run(60, 1, "toggling ready");
    run(1, 0, "single element");
    t_stall();
    t_zero();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule